// File: doc/BRIEF.md
# RTC Calibration Clock Selector

This block derives a calibration reference clock from the prescaler chain of a real-time clock. The chain has two stages, and both run from the 32.768 kHz source clock. The first stage is a 7-bit down-counter whose reload value software provides. The second is a 15-bit down-counter that steps once each time the first stage reaches zero. A fixed bit of one of these counters drives the calibration output. No programmable divider is involved, so the output frequency follows from the two reload values.

With the selector clear, the output is a square wave taken from bit 5 of the first-stage count. That is the source divided by 64 (512 Hz) when the first-stage reload is 0x7F. With the selector set, the output is taken from bit 7 of the second-stage count. Its period is 256 × (first reload + 1) source cycles, which is 1 Hz for reloads of 0x7F and 0xFF.

When the low-power calibration mode bit is set, the first-stage output comes from a free-running divide-by-64 counter. It is then present whatever the reload value. Whenever the output is disabled or the selected tap is not valid, the output is held low. Only rising edges are meant as timing references.

Top module: `rtc_calref_out`

## Requirements
- R1: While `rst_n` is low, `cal_clk` is 0 and all counters are cleared. The first clock edge after reset loads both stages from their reload inputs.
- R2: The first stage counts down from `async_reload` to 0 and then reloads. With `sel_sync`=0, `lp_cal`=0, `out_en`=1 and `async_reload` ≥ 0x20, `cal_clk` equals bit 5 of the first-stage count one cycle later. A reload of 0x7F gives a period of 64 cycles.
- R3: The second stage steps only in cycles where the first stage is 0. At such a step it decrements, or reloads from `sync_reload` when it is itself 0. With `sel_sync`=1, `out_en`=1 and a valid reload, `cal_clk` equals bit 7 of the second-stage count one cycle later. The period is 256 × (`async_reload`+1) cycles: 8448 cycles for 0x20/0xFF and 32768 cycles for 0x7F/0xFF.
- R4: With `sel_sync`=1, the second-stage reload is valid only when `sync_reload[7:0]` is 0xFF. Otherwise `cal_clk` stays 0.
- R5: With `sel_sync`=0 and `lp_cal`=0, an `async_reload` below 0x20 keeps `cal_clk` at 0.
- R6: With `sel_sync`=0 and `lp_cal`=1, `cal_clk` is bit 5 of a free-running 6-bit up-counter, one cycle later. The period is 64 cycles for any `async_reload`, including values below 0x20.
- R7: With `out_en`=0, `cal_clk` is 0 one cycle later. Both stages keep counting, so the phase is unchanged when the output is enabled again.
- R8: A change of `async_reload` or `sync_reload` takes effect only when that stage next reaches 0. The running count is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Calibration output enable |
| sel_sync | input | 1 | 1: tap the second stage; 0: tap the first stage |
| lp_cal | input | 1 | Low-power calibration mode for the first-stage tap |
| async_reload | input | 7 | First-stage reload value |
| sync_reload | input | 15 | Second-stage reload value |
| cal_clk | output | 1 | Calibration clock, held low when off or invalid |

## Verification
The bench builds the block with its default parameters: 7- and 15-bit stages, taps at bits 5 and 7, and an availability threshold of 0x20. Coverage of the slow output comes from the choice of reload values. A first-stage reload of 0x20 brings a full second-stage period of 8448 cycles within reach. The default 0x7F/0xFF pair then shows the 32768-cycle period. A scoreboard also follows every cycle across reload changes, disabled phases, invalid reloads and low-power mode.

// File: rtl/rtc_calref_pkg.sv
package rtc_calref_pkg;

   // Which tap feeds the output register
   typedef enum logic [1:0] {
      CALSRC_OFF   = 2'd0,
      CALSRC_ASYNC = 2'd1,
      CALSRC_LP    = 2'd2,
      CALSRC_SYNC  = 2'd3
   } calsrc_e;

   // Source choice: enable first, then the stage selector, then the mode bit
   function automatic calsrc_e pick_src(
      input logic en,
      input logic sel,
      input logic lp,
      input logic async_ok,
      input logic sync_ok
   );
      calsrc_e s;
      if (!en)          s = CALSRC_OFF;
      else if (sel)     s = sync_ok ? CALSRC_SYNC : CALSRC_OFF;
      else if (lp)      s = CALSRC_LP;
      else if (async_ok) s = CALSRC_ASYNC;
      else              s = CALSRC_OFF;
      return s;
   endfunction

endpackage

// File: rtl/rtc_calref_async_div.sv
// First prescaler stage: free-running down-counter with reload at zero.
module rtc_calref_async_div #(
   parameter int unsigned W   = 7,
   parameter int unsigned TAP = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] reload,
   output logic [W-1:0] cnt,
   output logic         zero,
   output logic         tap
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   assign zero = (cnt_q == '0);

   always_comb begin
      if (zero) cnt_d = reload;
      else      cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;
   assign tap = cnt_q[TAP];

endmodule

// File: rtl/rtc_calref_sync_div.sv
// Second prescaler stage: steps only on the first stage's terminal count.
module rtc_calref_sync_div #(
   parameter int unsigned W   = 15,
   parameter int unsigned TAP = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] reload,
   output logic [W-1:0] cnt,
   output logic         tap
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;
   logic         at_zero;

   assign at_zero = (cnt_q == '0);

   always_comb begin
      cnt_d = cnt_q;
      if (step) begin
         if (at_zero) cnt_d = reload;
         else         cnt_d = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;
   assign tap = cnt_q[TAP];

endmodule

// File: rtl/rtc_calref_lp_div.sv
// Low-power calibration path: free-running power-of-two divider whose
// MSB toggles every 2**TAP cycles, independent of any reload value.
module rtc_calref_lp_div #(
   parameter int unsigned TAP = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic tap
);

   localparam int unsigned LW = TAP + 1;

   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign tap = cnt_q[LW-1];

endmodule

// File: rtl/rtc_calref_gate.sv
// Validity decode, source selection and glitch-free output register.
module rtc_calref_gate
   import rtc_calref_pkg::*;
#(
   parameter int unsigned AW        = 7,
   parameter int unsigned SW        = 15,
   parameter int unsigned SYNC_TAP  = 7,
   parameter int unsigned ASYNC_MIN = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          out_en,
   input  logic          sel_sync,
   input  logic          lp_cal,
   input  logic [AW-1:0] async_reload,
   input  logic [SW-1:0] sync_reload,
   input  logic          async_tap,
   input  logic          lp_tap,
   input  logic          sync_tap,
   output logic          cal_clk
);

   localparam int unsigned MW = SYNC_TAP + 1;

   logic    async_ok;
   logic    sync_ok;
   calsrc_e src;
   logic    nxt;

   // First-stage availability: a zero threshold means always available
   generate
      if (ASYNC_MIN == 0) begin : g_async_always
         assign async_ok = 1'b1;
      end else begin : g_async_thresh
         localparam logic [AW-1:0] MIN_V = AW'(ASYNC_MIN);
         assign async_ok = (async_reload >= MIN_V);
      end
   endgenerate

   // Second stage is regular only when (reload+1) is a multiple of 2**MW
   generate
      if (MW == SW) begin : g_sync_full
         assign sync_ok = &sync_reload;
      end else begin : g_sync_low
         logic [SW-MW-1:0] hi_unused;
         assign hi_unused = sync_reload[SW-1:MW];
         assign sync_ok   = &sync_reload[MW-1:0];
      end
   endgenerate

   assign src = pick_src(out_en, sel_sync, lp_cal, async_ok, sync_ok);

   always_comb begin
      unique case (src)
         CALSRC_ASYNC: nxt = async_tap;
         CALSRC_LP:    nxt = lp_tap;
         CALSRC_SYNC:  nxt = sync_tap;
         default:      nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cal_clk <= 1'b0;
      else        cal_clk <= nxt;
   end

endmodule

// File: rtl/rtc_calref_out.sv
module rtc_calref_out #(
   parameter int unsigned ASYNC_W   = 7,
   parameter int unsigned SYNC_W    = 15,
   parameter int unsigned ASYNC_TAP = 5,
   parameter int unsigned SYNC_TAP  = 7,
   parameter int unsigned ASYNC_MIN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               out_en,
   input  logic               sel_sync,
   input  logic               lp_cal,
   input  logic [ASYNC_W-1:0] async_reload,
   input  logic [SYNC_W-1:0]  sync_reload,
   output logic               cal_clk
);

   localparam int unsigned ASYNC_SPAN = 1 << ASYNC_W;

   generate
      if (ASYNC_TAP >= ASYNC_W) begin : g_bad_atap
         $error("ASYNC_TAP must lie inside the first stage");
      end
      if (SYNC_TAP >= SYNC_W) begin : g_bad_stap
         $error("SYNC_TAP must lie inside the second stage");
      end
      if (ASYNC_MIN >= ASYNC_SPAN) begin : g_bad_min
         $error("ASYNC_MIN exceeds the first-stage range");
      end
   endgenerate

   logic [ASYNC_W-1:0] a_cnt;
   logic [SYNC_W-1:0]  s_cnt;
   logic               a_zero;
   logic               a_tap;
   logic               s_tap;
   logic               lp_tap;

   rtc_calref_async_div #(.W(ASYNC_W), .TAP(ASYNC_TAP)) u_adiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (async_reload),
      .cnt    (a_cnt),
      .zero   (a_zero),
      .tap    (a_tap)
   );

   rtc_calref_sync_div #(.W(SYNC_W), .TAP(SYNC_TAP)) u_sdiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (a_zero),
      .reload (sync_reload),
      .cnt    (s_cnt),
      .tap    (s_tap)
   );

   rtc_calref_lp_div #(.TAP(ASYNC_TAP)) u_lpdiv (
      .clk   (clk),
      .rst_n (rst_n),
      .tap   (lp_tap)
   );

   rtc_calref_gate #(
      .AW        (ASYNC_W),
      .SW        (SYNC_W),
      .SYNC_TAP  (SYNC_TAP),
      .ASYNC_MIN (ASYNC_MIN)
   ) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .out_en       (out_en),
      .sel_sync     (sel_sync),
      .lp_cal       (lp_cal),
      .async_reload (async_reload),
      .sync_reload  (sync_reload),
      .async_tap    (a_tap),
      .lp_tap       (lp_tap),
      .sync_tap     (s_tap),
      .cal_clk      (cal_clk)
   );

endmodule

// File: rtl/rtc_calref_out_chk.sv
module rtc_calref_out_chk #(
   parameter int unsigned ASYNC_W   = 7,
   parameter int unsigned SYNC_W    = 15,
   parameter int unsigned SYNC_TAP  = 7,
   parameter int unsigned ASYNC_MIN = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               out_en,
   input logic               sel_sync,
   input logic               lp_cal,
   input logic [ASYNC_W-1:0] async_reload,
   input logic [SYNC_W-1:0]  sync_reload,
   input logic [ASYNC_W-1:0] a_cnt,
   input logic [SYNC_W-1:0]  s_cnt,
   input logic               lp_tap,
   input logic               cal_clk
);

   localparam logic [ASYNC_W-1:0] AMIN_V = ASYNC_W'(ASYNC_MIN);

   p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !cal_clk);

   p_async_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_cnt == '0) |=> (a_cnt == $past(async_reload)));

   p_async_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_cnt != '0) |=> (a_cnt == $past(a_cnt) - 1'b1));

   p_sync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_cnt != '0) |=> $stable(s_cnt));

   p_sync_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_cnt == '0 && s_cnt != '0) |=> (s_cnt == $past(s_cnt) - 1'b1));

   p_sync_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && sel_sync && !(&sync_reload[SYNC_TAP:0])) |=> !cal_clk);

   p_async_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_sync && !lp_cal && async_reload < AMIN_V) |=> !cal_clk);

   p_lp_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && !sel_sync && lp_cal) |=> (cal_clk == $past(lp_tap)));

   p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> !cal_clk);

endmodule

bind rtc_calref_out rtc_calref_out_chk #(
   .ASYNC_W   (ASYNC_W),
   .SYNC_W    (SYNC_W),
   .SYNC_TAP  (SYNC_TAP),
   .ASYNC_MIN (ASYNC_MIN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .out_en       (out_en),
   .sel_sync     (sel_sync),
   .lp_cal       (lp_cal),
   .async_reload (async_reload),
   .sync_reload  (sync_reload),
   .a_cnt        (a_cnt),
   .s_cnt        (s_cnt),
   .lp_tap       (lp_tap),
   .cal_clk      (cal_clk)
);

// File: tb/rtc_calref_out_test.sv
module rtc_calref_out_test;

   logic        clk;
   logic        rst_n;
   logic        out_en;
   logic        sel_sync;
   logic        lp_cal;
   logic [6:0]  async_reload;
   logic [14:0] sync_reload;
   logic        cal_clk;

   int     checks = 0;
   int     errors = 0;
   longint cyc    = 0;
   bit     done   = 0;

   rtc_calref_out uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .out_en       (out_en),
      .sel_sync     (sel_sync),
      .lp_cal       (lp_cal),
      .async_reload (async_reload),
      .sync_reload  (sync_reload),
      .cal_clk      (cal_clk)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input longint act, input longint exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   // ---------------- scoreboard model, built from the requirements ----------
   bit    q_exp[$];
   string q_tag[$];
   logic [6:0]  m_a;
   logic [14:0] m_s;
   logic [5:0]  m_lp;

   always @(posedge clk) begin
      bit    e;
      string t;
      if (!rst_n) begin
         m_a = '0; m_s = '0; m_lp = '0;
         e = 1'b0; t = "R1";
      end else begin
         if (!out_en) begin
            e = 1'b0; t = "R7";
         end else if (sel_sync) begin
            if (sync_reload[7:0] == 8'hFF) begin e = m_s[7]; t = "R3"; end
            else begin e = 1'b0; t = "R4"; end
         end else if (lp_cal) begin
            e = m_lp[5]; t = "R6";
         end else if (async_reload >= 7'h20) begin
            e = m_a[5]; t = "R2";
         end else begin
            e = 1'b0; t = "R5";
         end
         // R8: reload values are sampled only at zero
         if (m_a == 0) begin
            m_s = (m_s == 0) ? sync_reload : m_s - 1'b1;
            m_a = async_reload;
         end else begin
            m_a = m_a - 1'b1;
         end
         m_lp = m_lp + 1'b1;
      end
      q_exp.push_back(e);
      q_tag.push_back(t);
   end

   // monitor: pops and compares away from the active edge
   always @(negedge clk) begin
      if (!done && q_exp.size() > 0) begin
         bit    e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         check(t, longint'(cal_clk), longint'(e), "scoreboard");
      end
   end

   // ---------------- driver helpers ----------------
   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic next_rise(output longint c);
      logic prev;
      bit   seen;
      prev = cal_clk;
      seen = 0;
      while (!seen) begin
         @(negedge clk);
         if (cal_clk && !prev) begin
            c = cyc;
            seen = 1;
         end
         prev = cal_clk;
      end
   endtask

   task automatic count_rises(input int n, output int r);
      logic prev;
      prev = cal_clk;
      r = 0;
      repeat (n) begin
         @(negedge clk);
         if (cal_clk && !prev) r++;
         prev = cal_clk;
      end
   endtask

   task automatic period_check(input string tag, input int skip, input longint exp);
      longint c0, c1;
      for (int i = 0; i < skip; i++) next_rise(c0);
      next_rise(c0);
      next_rise(c1);
      check(tag, c1 - c0, exp, "rising-edge period");
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int r;
      rst_n = 1'b0; out_en = 1'b1; sel_sync = 1'b0; lp_cal = 1'b0;
      async_reload = 7'h7F; sync_reload = 15'h00FF;
      run(5);
      check("R1", longint'(cal_clk), 0, "output during reset");
      rst_n = 1'b1;
      run(1);
      check("R1", longint'(cal_clk), 0, "output after first edge");

      // R2: 512 Hz style tap with reload 0x7F
      period_check("R2", 1, 64);
      run(100);

      // R8: new reload only at the next zero (scoreboard follows the count)
      async_reload = 7'h3F;
      run(40);
      period_check("R8", 2, 64);

      // R5: reload below threshold, no low-power mode
      async_reload = 7'h1F;
      run(2);
      count_rises(200, r);
      check("R5", r, 0, "rises with short reload");

      // R6: low-power mode keeps a 64-cycle output with a tiny reload
      lp_cal = 1'b1;
      async_reload = 7'h05;
      period_check("R6", 1, 64);
      run(50);

      // R7: disabled output stays low; phase kept (scoreboard)
      out_en = 1'b0;
      run(2);
      count_rises(200, r);
      check("R7", r, 0, "rises while disabled");
      out_en = 1'b1;
      run(150);

      // R4: invalid second-stage reload
      lp_cal = 1'b0;
      sel_sync = 1'b1;
      sync_reload = 15'h00FE;
      async_reload = 7'h20;
      run(2);
      count_rises(600, r);
      check("R4", r, 0, "rises with invalid sync reload");

      // R3: 256 * (0x20+1) cycles
      sync_reload = 15'h00FF;
      period_check("R3", 1, 8448);

      // R3: full 1 Hz period with 0x7F / 0xFF
      async_reload = 7'h7F;
      period_check("R3", 1, 32768);

      run(3);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule